// File: doc/BRIEF.md
# DMA Bus-Request Front End with Interrupt-Before-Request

This block sits at the front of a DMA controller and decides when to ask the CPU for the bus. It watches an asynchronous Ready line from an I/O device. When requesting is enabled and Ready is high, it drives an active-low bus request. The request stays low while the CPU grants the bus. It is withdrawn when the transfer engine reports that the transfer is done.

An optional mode sends the first Ready activation to the CPU as an interrupt instead of a bus request. The interrupt turns requesting off. The service routine can then reprogram the controller and write an enable command, which clears the interrupt and lets the request go out.

In continuous mode this interrupt is raised only once, on the first activation. Later Ready activations do not raise it again until a reset command. In byte mode the one-shot is re-armed after each completed transfer.

Software drives the block through an 8-bit command write port.

Top module: `dma_busreq_front`

## Requirements
- R1: After `rst_n` is low, `busreq_n` and `int_n` are both high.
- R2: With requesting enabled and interrupt-before-request off, Ready going high is sampled on a rising edge, and `busreq_n` is low after the second rising edge that follows. It is not low earlier.
- R3: With interrupt-before-request on (command 0xA0 sets it, 0xA1 clears it), a Ready rise observed while enabled and not yet fired drives `int_n` low with the same latency as R2. No bus request is made.
- R4: While `int_n` is low, `busreq_n` stays high. The interrupt turns requesting off. After an enable command (0x87), `int_n` goes high at that edge, and, if Ready is high, `busreq_n` goes low on the next edge.
- R5: In continuous mode (0xC0 sets it, 0xC1 clears it), once the interrupt has fired, further Ready rises raise no interrupt until a reset command.
- R6: In byte mode, a completed transfer re-arms the interrupt. The next Ready rise raises `int_n` again. While the interrupt is armed, Ready staying high makes no request.
- R7: The reset command (0xC3) clears the enable, the pending interrupt, the fired flag and the request. It leaves both outputs high on the next edge.
- R8: The acknowledge command (0xB0) clears a pending interrupt and leaves requesting off.
- R9: Once low, `busreq_n` stays low until `xfer_done` is high in a cycle in which `busack_n` is low. It then rises at that edge. With continuous mode on, enabled, and Ready still high, it falls again one edge later.
- R10: The disable command (0x83), written while `busreq_n` is low and `busack_n` is high, raises `busreq_n` at that edge.
- R11: The disable command written while `busack_n` is low does not withdraw the request. It only stops new requests after the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy | input | 1 | Device Ready, asynchronous, active high |
| busack_n | input | 1 | Bus grant from CPU, active low |
| xfer_done | input | 1 | Pulse from the transfer engine when the transfer ends |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| busreq_n | output | 1 | Bus request to CPU, active low |
| int_n | output | 1 | Interrupt to CPU, active low |

## Verification
The hardest state to reach is continuous mode after the one-shot interrupt has fired, with the bus already granted. In that state, a fresh Ready rise must stay silent while the request persists.

The stimulus gets there in steps. It turns on both modes and raises Ready to fire the interrupt. An enable command then releases the request and a grant is given. After one completed transfer, the re-request is observed. Ready is then dropped and raised again while the grant is held.

A similar path checks byte mode. There the completed transfer must re-arm the interrupt, and the next Ready rise must raise `int_n` again.

// File: rtl/dma_busreq_front.sv
module dma_busreq_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rdy,
  input  logic       busack_n,
  input  logic       xfer_done,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  output logic       busreq_n,
  output logic       int_n
);
  localparam logic [7:0] CMD_RST  = 8'hC3;
  localparam logic [7:0] CMD_EN   = 8'h87;
  localparam logic [7:0] CMD_DIS  = 8'h83;
  localparam logic [7:0] CMD_IRON = 8'hA0;
  localparam logic [7:0] CMD_IROF = 8'hA1;
  localparam logic [7:0] CMD_ACK  = 8'hB0;
  localparam logic [7:0] CMD_CON  = 8'hC0;
  localparam logic [7:0] CMD_COF  = 8'hC1;

  logic s1, s2, s3;
  logic en, irdy_mode, cont, fired, pend, req;

  wire c_rst  = cmd_we && cmd_data == CMD_RST;
  wire c_en   = cmd_we && cmd_data == CMD_EN;
  wire c_dis  = cmd_we && cmd_data == CMD_DIS;
  wire c_ack  = cmd_we && cmd_data == CMD_ACK;
  wire rise   = s2 && !s3;
  wire int_ev = rise && en && irdy_mode && !fired && !req;
  wire block  = irdy_mode && !fired;
  wire req_set = en && s2 && !block;
  wire finish = req && !busack_n && xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= 3'b000;
    end else begin
      s1 <= rdy;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irdy_mode <= 1'b0;
      cont      <= 1'b0;
    end else if (cmd_we) begin
      if (cmd_data == CMD_IRON) irdy_mode <= 1'b1;
      if (cmd_data == CMD_IROF) irdy_mode <= 1'b0;
      if (cmd_data == CMD_CON)  cont      <= 1'b1;
      if (cmd_data == CMD_COF)  cont      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      fired <= 1'b0;
      pend  <= 1'b0;
      req   <= 1'b0;
    end else if (c_rst) begin
      en    <= 1'b0;
      fired <= 1'b0;
      pend  <= 1'b0;
      req   <= 1'b0;
    end else begin
      if (int_ev)     en <= 1'b0;
      else if (c_en)  en <= 1'b1;
      else if (c_dis) en <= 1'b0;

      if (int_ev)              fired <= 1'b1;
      else if (finish && !cont) fired <= 1'b0;

      if (int_ev)              pend <= 1'b1;
      else if (c_ack || c_en)  pend <= 1'b0;

      if (req) begin
        if (busack_n && c_dis) req <= 1'b0;
        else if (finish)       req <= 1'b0;
      end else begin
        req <= req_set;
      end
    end
  end

  assign busreq_n = !req;
  assign int_n    = !pend;

  // R2
  property p_latency;
    @(posedge clk) disable iff (!rst_n)
      (en && !irdy_mode && s2 && busreq_n && !cmd_we) |=> !busreq_n;
  endproperty
  req_latency_chk: assert property (p_latency);

  // R4
  property p_int_holds;
    @(posedge clk) disable iff (!rst_n) !int_n |-> busreq_n;
  endproperty
  int_blocks_req_chk: assert property (p_int_holds);

  // R7
  property p_rst_cmd;
    @(posedge clk) disable iff (!rst_n) c_rst |=> (busreq_n && int_n);
  endproperty
  rst_cmd_clear_chk: assert property (p_rst_cmd);

  // R9
  property p_hold;
    @(posedge clk) disable iff (!rst_n)
      (!busreq_n && !busack_n && !xfer_done && !c_rst) |=> !busreq_n;
  endproperty
  req_hold_chk: assert property (p_hold);

  // R10
  property p_withdraw;
    @(posedge clk) disable iff (!rst_n)
      (!busreq_n && busack_n && c_dis) |=> busreq_n;
  endproperty
  dis_withdraw_chk: assert property (p_withdraw);

  // R11
  property p_dis_granted;
    @(posedge clk) disable iff (!rst_n)
      (!busreq_n && !busack_n && c_dis && !xfer_done) |=> !busreq_n;
  endproperty
  dis_granted_chk: assert property (p_dis_granted);
endmodule

// File: tb/dma_busreq_front_test.sv
module dma_busreq_front_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy = 1'b0, busack_n = 1'b1, xfer_done = 1'b0, cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic busreq_n, int_n;

  int tests = 0, fails = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_busreq_front uut (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .busack_n(busack_n),
    .xfer_done(xfer_done), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .busreq_n(busreq_n), .int_n(int_n)
  );

  // behavioural reference: ready history, mode flags and request state
  bit hist[$];
  bit m_en, m_ir, m_cont, m_fired, m_pend, m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {0, 0, 0};
      m_en = 0; m_ir = 0; m_cont = 0; m_fired = 0; m_pend = 0; m_req = 0;
    end else begin
      bit now_hi, was_hi, ev, grant_end;
      now_hi = hist[1];
      was_hi = hist[2];
      ev = now_hi && !was_hi && m_en && m_ir && !m_fired && !m_req;
      grant_end = m_req && !busack_n && xfer_done;
      if (cmd_we && cmd_data == 8'hC3) begin
        m_en = 0; m_fired = 0; m_pend = 0; m_req = 0;
      end else begin
        bit nxt_req;
        if (m_req) nxt_req = !((busack_n && cmd_we && cmd_data == 8'h83) || grant_end);
        else nxt_req = m_en && now_hi && !(m_ir && !m_fired);
        if (ev) begin
          m_pend = 1; m_fired = 1; m_en = 0;
        end else begin
          if (cmd_we && (cmd_data == 8'hB0 || cmd_data == 8'h87)) m_pend = 0;
          if (cmd_we && cmd_data == 8'h87) m_en = 1;
          if (cmd_we && cmd_data == 8'h83) m_en = 0;
          if (grant_end && !m_cont) m_fired = 0;
        end
        m_req = nxt_req;
      end
      if (cmd_we) begin
        if (cmd_data == 8'hA0) m_ir = 1;
        if (cmd_data == 8'hA1) m_ir = 0;
        if (cmd_data == 8'hC0) m_cont = 1;
        if (cmd_data == 8'hC1) m_cont = 0;
      end
      hist.push_front(rdy);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      tests++;
      if (busreq_n !== !m_req || int_n !== !m_pend) begin
        fails++;
        $display("FAIL model: busreq_n=%b int_n=%b expected %b %b", busreq_n, int_n, !m_req, !m_pend);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_we = 1; cmd_data = b;
    @(negedge clk);
    cmd_we = 0; cmd_data = 8'h00;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    check("R1 busreq_n", busreq_n, 1'b1);
    check("R1 int_n", int_n, 1'b1);
    rst_n = 1;
    tick(1);

    // R2 latency and R10 withdraw before grant
    cmd(8'h87);
    rdy = 1;
    tick(2);
    check("R2 not early", busreq_n, 1'b1);
    tick(1);
    check("R2 low", busreq_n, 1'b0);
    cmd(8'h83);
    check("R10 withdraw", busreq_n, 1'b1);
    rdy = 0; tick(3);

    // R11 and R9
    cmd(8'h87);
    rdy = 1; tick(3);
    busack_n = 0; tick(1);
    cmd(8'h83);
    check("R11 held", busreq_n, 1'b0);
    tick(2);
    check("R9 hold", busreq_n, 1'b0);
    xfer_done = 1; tick(1); xfer_done = 0;
    check("R9 release", busreq_n, 1'b1);
    busack_n = 1; rdy = 0; tick(3);

    // R3, R4, R8, R6 in byte mode
    cmd(8'hA0);
    cmd(8'h87);
    rdy = 1; tick(3);
    check("R3 int", int_n, 1'b0);
    check("R3 no req", busreq_n, 1'b1);
    tick(4);
    check("R4 off", busreq_n, 1'b1);
    cmd(8'hB0);
    check("R8 ack", int_n, 1'b1);
    tick(1);
    check("R8 no req", busreq_n, 1'b1);
    cmd(8'h87);
    check("R4 int clr", int_n, 1'b1);
    tick(1);
    check("R4 req", busreq_n, 1'b0);
    busack_n = 0; xfer_done = 1; tick(1); xfer_done = 0; busack_n = 1;
    tick(1);
    check("R6 armed no req", busreq_n, 1'b1);
    rdy = 0; tick(3);
    rdy = 1; tick(3);
    check("R6 int again", int_n, 1'b0);

    // R7 reset command, then R5 continuous mode
    cmd(8'hC3);
    check("R7 int", int_n, 1'b1);
    check("R7 req", busreq_n, 1'b1);
    cmd(8'hC0);
    cmd(8'h87);
    rdy = 0; tick(3);
    rdy = 1; tick(3);
    check("R5 first int", int_n, 1'b0);
    cmd(8'h87);
    tick(1);
    check("R5 req", busreq_n, 1'b0);
    busack_n = 0; xfer_done = 1; tick(1); xfer_done = 0;
    check("R9 done", busreq_n, 1'b1);
    tick(1);
    check("R9 continuous re-request", busreq_n, 1'b0);
    rdy = 0; tick(3);
    rdy = 1; tick(4);
    check("R5 no second int", int_n, 1'b1);
    check("R5 req held", busreq_n, 1'b0);
    rdy = 0; xfer_done = 1; tick(1); xfer_done = 0; busack_n = 1;
    tick(3);
    rdy = 1; tick(3);
    check("R5 still silent", int_n, 1'b1);
    cmd(8'hC3);
    check("R7 after cont", busreq_n, 1'b1);
    cmd(8'hA1); cmd(8'hC1);
    tick(2);
    finish_run();
  end
endmodule